// File: doc/BRIEF.md
# RS-485 Driver-Enable Sequencer

This block sits between a UART transmit data register and the transmit shifter. It produces the active-high enable for an external bus transceiver on a shared half-duplex line. A write to the transmit data register raises the enable at once. The block then holds the shifter back for a lead time of one to two bit periods, counted on the baud generator's bit tick. After that it pulses a go strobe so the shifter emits the start bit. The enable stays high through the data, parity and stop bits. It drops in the cycle after the shifter reports the end of the last stop bit. The exception is a byte written while the frame was in flight. In that case the next frame is launched on that same end-of-frame cycle and the enable never dips.

A mode input selects whether the transceiver is driven at all. With the mode off, the enable is held low and frames are launched with no lead delay. Four states carry the behaviour. ST_IDLE waits for a byte. ST_LEAD_ALIGN waits for the first bit tick after the write. ST_LEAD_FULL waits one more full tick. ST_FRAME covers the frame in flight.

The transitions are as follows:
- ST_IDLE to ST_LEAD_ALIGN happens on a waiting byte with the mode on.
- ST_IDLE to ST_FRAME happens on a waiting byte with the mode off and the shifter idle.
- ST_LEAD_ALIGN to ST_LEAD_FULL happens on a tick.
- ST_LEAD_FULL to ST_FRAME happens on a tick with the shifter idle.
- Either lead state goes to ST_FRAME when the mode is switched off.
- ST_FRAME goes to ST_IDLE on end of frame with no byte waiting.
- ST_FRAME stays in ST_FRAME on end of frame with a byte waiting.

Top module: `rs485_de_gen`

## Requirements
- R1: After reset, `drv_en` and `shift_go` are both 0.
- R2: With `de_enable` = 1 and the block idle, `drv_en` is 1 in the cycle after the cycle in which `tx_write` is 1.
- R3: With `de_enable` = 1, `drv_en` is 1 in every cycle in which `shift_busy` is 1 (start, data, parity and stop bits) and in the `frame_done` cycle.
- R4: The start bit begins in the cycle after the `shift_go` pulse. `shift_go` coincides with the second `bit_tick` seen from the cycle where `drv_en` rose. If the first such tick comes k cycles after the write cycle (1 <= k <= P, where P is the tick period), the start bit begins k+P cycles after `drv_en` rose. That is a lead between P+1 and 2P cycles.
- R5: With no byte waiting, `drv_en` is 0 in the cycle after the `frame_done` cycle.
- R6: A `tx_write` during a frame in flight launches the next frame with `shift_go` in that frame's `frame_done` cycle. `drv_en` stays 1 without a gap until the second frame's `frame_done`.
- R7: A `tx_write` during the lead wait neither restarts the wait nor produces an extra frame.
- R8: With `de_enable` = 0, `drv_en` stays 0. A write while the shifter is idle gives `shift_go` in the write cycle itself.
- R9: `shift_go` is never 1 while `shift_busy` is 1, except in a `frame_done` cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| de_enable | input | 1 | 1: drive the transceiver enable with lead time; 0: enable held low, no lead |
| tx_write | input | 1 | One-cycle strobe: a byte was written to the transmit data register |
| bit_tick | input | 1 | One-cycle pulse per bit period from the baud generator |
| shift_busy | input | 1 | Shifter is sending a frame |
| frame_done | input | 1 | One-cycle pulse: the last stop bit ends |
| drv_en | output | 1 | Transceiver driver enable, active high |
| shift_go | output | 1 | One-cycle strobe telling the shifter to start the start bit |

## Verification
The bench places the write at every distance from the next tick, from one cycle to a full period. A design that counted only one tick, or restarted on the write phase, would give a lead outside P+1 to 2P. A second write is placed inside the lead wait; a design that restarted the wait would show a longer lead, and one that queued the write would send two frames. A write during a frame must chain on the end-of-frame cycle; a design that released the enable between frames would show a gap or two falling edges. With the mode off, any enable pulse or any lead delay before the go strobe is reported.

// File: rtl/rs485_de_pkg.sv
package rs485_de_pkg;

    typedef enum logic [1:0] {
        ST_IDLE       = 2'd0,
        ST_LEAD_ALIGN = 2'd1,
        ST_LEAD_FULL  = 2'd2,
        ST_FRAME      = 2'd3
    } de_state_t;

    localparam int unsigned STATE_W = $bits(de_state_t);

endpackage

// File: rtl/rs485_de_pending.sv
module rs485_de_pending (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic take_i,
    output logic held_o
);
    logic held_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            held_q <= 1'b0;
        end else if (take_i) begin
            held_q <= 1'b0;
        end else if (set_i) begin
            held_q <= 1'b1;
        end
    end

    assign held_o = held_q;
endmodule

// File: rtl/rs485_de_fsm.sv
module rs485_de_fsm
    import rs485_de_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      mode_on,
    input  logic      wr_now,
    input  logic      held,
    input  logic      tick,
    input  logic      busy,
    input  logic      done,
    output logic      pend_set,
    output logic      pend_take,
    output logic      de_o,
    output logic      go_o,
    output de_state_t state_o
);
    de_state_t state_q, state_d;
    logic byte_ready;

    assign byte_ready = wr_now | held;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (byte_ready) begin
                    if (mode_on) begin
                        state_d = ST_LEAD_ALIGN;
                    end else if (!busy) begin
                        state_d = ST_FRAME;
                    end
                end
            end
            ST_LEAD_ALIGN: begin
                if (!mode_on) begin
                    if (!busy) state_d = ST_FRAME;
                end else if (tick) begin
                    state_d = ST_LEAD_FULL;
                end
            end
            ST_LEAD_FULL: begin
                if (!mode_on || tick) begin
                    if (!busy) state_d = ST_FRAME;
                end
            end
            ST_FRAME: begin
                if (done && !byte_ready) begin
                    state_d = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        go_o      = 1'b0;
        pend_take = 1'b0;
        pend_set  = 1'b0;
        de_o      = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                pend_set = wr_now;
                if (byte_ready && (mode_on || !busy)) begin
                    pend_take = 1'b1;
                    go_o      = !mode_on;
                end
            end
            ST_LEAD_ALIGN: begin
                de_o = mode_on;
                go_o = !mode_on && !busy;
            end
            ST_LEAD_FULL: begin
                de_o = mode_on;
                go_o = (!mode_on || tick) && !busy;
            end
            ST_FRAME: begin
                de_o     = mode_on;
                pend_set = wr_now;
                if (done && byte_ready) begin
                    go_o      = 1'b1;
                    pend_take = 1'b1;
                end
            end
            default: ;
        endcase
    end

    assign state_o = state_q;
endmodule

// File: rtl/rs485_de_gen.sv
module rs485_de_gen
    import rs485_de_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic de_enable,
    input  logic tx_write,
    input  logic bit_tick,
    input  logic shift_busy,
    input  logic frame_done,
    output logic drv_en,
    output logic shift_go
);
    logic      byte_held;
    logic      hold_set;
    logic      hold_take;
    de_state_t cur_state;

    rs485_de_pending u_pending (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (hold_set),
        .take_i (hold_take),
        .held_o (byte_held)
    );

    rs485_de_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode_on   (de_enable),
        .wr_now    (tx_write),
        .held      (byte_held),
        .tick      (bit_tick),
        .busy      (shift_busy),
        .done      (frame_done),
        .pend_set  (hold_set),
        .pend_take (hold_take),
        .de_o      (drv_en),
        .go_o      (shift_go),
        .state_o   (cur_state)
    );

    logic unused_state;
    assign unused_state = ^cur_state;
endmodule

// File: rtl/rs485_de_gen_chk.sv
module rs485_de_gen_chk (
    input logic clk,
    input logic rst_n,
    input logic de_enable,
    input logic tx_write,
    input logic bit_tick,
    input logic shift_busy,
    input logic frame_done,
    input logic drv_en,
    input logic shift_go
);
    logic [1:0] ticks_q;
    logic       armed_q;
    logic       de_q;
    logic       wr_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ticks_q <= 2'd0;
            armed_q <= 1'b0;
            de_q    <= 1'b0;
            wr_q    <= 1'b0;
        end else begin
            de_q <= drv_en;
            wr_q <= tx_write;
            if (!drv_en) begin
                ticks_q <= 2'd0;
                armed_q <= 1'b0;
            end else begin
                if (bit_tick && ticks_q != 2'd3) ticks_q <= ticks_q + 2'd1;
                if (shift_go) armed_q <= 1'b0;
                else if (!de_q && wr_q) armed_q <= 1'b1;
            end
        end
    end

    assert_de_after_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_write && de_enable && !drv_en && !shift_busy) |=> (drv_en || !de_enable));

    assert_frame_covered_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ((shift_busy || frame_done) && de_enable) |-> drv_en);

    assert_lead_two_ticks_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (shift_go && armed_q) |-> (({1'b0, ticks_q} + {2'b00, bit_tick}) >= 3'd2));

    assert_no_go_on_rise_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (drv_en && !de_q && wr_q) |-> !shift_go);

    assert_low_when_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !de_enable |-> !drv_en);

    assert_go_not_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
        shift_go |-> (!shift_busy || frame_done));
endmodule

bind rs485_de_gen rs485_de_gen_chk u_rs485_de_gen_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .de_enable  (de_enable),
    .tx_write   (tx_write),
    .bit_tick   (bit_tick),
    .shift_busy (shift_busy),
    .frame_done (frame_done),
    .drv_en     (drv_en),
    .shift_go   (shift_go)
);

// File: tb/test_rs485_de_gen.sv
`timescale 1ns/1ps
module test_rs485_de_gen;
    localparam int P  = 8;
    localparam int NB = 11;
    localparam int NV = 6;
    localparam int VK[NV]    = '{1, 3, 5, 8, 4, 2};
    localparam bit VEN[NV]   = '{1, 1, 1, 1, 0, 1};
    localparam int VLEAD[NV] = '{9, 11, 13, 16, 1, 10};

    logic clk = 0, rst_n = 0;
    logic de_enable = 1, tx_write = 0;
    logic bit_tick, shift_busy, frame_done, drv_en, shift_go;
    int cyc = 0;
    int total = 0, bad = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;
    assign bit_tick = (cyc % P) == (P - 1);

    int bcnt;
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shift_busy <= 1'b0; bcnt <= 0;
        end else if (shift_go) begin
            shift_busy <= 1'b1; bcnt <= 0;
        end else if (frame_done) begin
            shift_busy <= 1'b0;
        end else if (shift_busy && bit_tick) begin
            bcnt <= bcnt + 1;
        end
    end
    assign frame_done = shift_busy && bit_tick && (bcnt == NB - 1);

    rs485_de_gen i_rs485_de_gen (
        .clk(clk), .rst_n(rst_n), .de_enable(de_enable), .tx_write(tx_write),
        .bit_tick(bit_tick), .shift_busy(shift_busy), .frame_done(frame_done),
        .drv_en(drv_en), .shift_go(shift_go)
    );

    int rise_c, fall_c, go_c, go2_c, done1_c, done_c, go_n, done_n, fall_n, gaps, hi_n, badgo;
    logic de_prev = 0;
    always @(negedge clk) begin
        if (drv_en && !de_prev) rise_c = cyc;
        if (!drv_en && de_prev) begin fall_c = cyc; fall_n++; end
        if (shift_go) begin
            if (go_n == 0) go_c = cyc; else go2_c = cyc;
            go_n++;
            if (shift_busy && !frame_done) badgo++;
        end
        if (frame_done) begin
            if (done_n == 0) done1_c = cyc;
            done_c = cyc; done_n++;
        end
        if (de_enable && shift_busy && !drv_en) gaps++;
        if (drv_en) hi_n++;
        de_prev = drv_en;
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic clear_mon();
        @(posedge clk); #1;
        rise_c = -1; fall_c = -1; go_c = -1; go2_c = -1; done1_c = -1; done_c = -1;
        go_n = 0; done_n = 0; fall_n = 0; gaps = 0; hi_n = 0;
    endtask

    // write so that the first tick falls k cycles after the write cycle
    task automatic write_at_phase(input int k, output int wcyc);
        forever begin
            @(posedge clk); #1;
            if ((cyc + k) % P == P - 1) break;
        end
        wcyc = cyc;
        tx_write = 1;
        @(posedge clk); #1;
        tx_write = 0;
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 600; i++) begin
            @(posedge clk); #1;
            if (go_n > 0 && done_n >= go_n && !shift_busy && !drv_en) break;
        end
        repeat (3) @(posedge clk);
        #1;
    endtask

    initial begin
        int w;
        badgo = 0;
        clear_mon();
        repeat (3) @(posedge clk);
        #1;
        check(drv_en == 0, "R1 de in reset", drv_en, 0);
        check(shift_go == 0, "R1 go in reset", shift_go, 0);
        rst_n = 1;
        repeat (2) @(posedge clk);
        #1;
        check(drv_en == 0 && shift_go == 0, "R1 after reset", {drv_en, shift_go}, 0);

        for (int v = 0; v < NV; v++) begin
            de_enable = VEN[v];
            clear_mon();
            write_at_phase(VK[v], w);
            wait_idle();
            if (VEN[v]) begin
                check(rise_c == w + 1, "R2 de rise cycle", rise_c, w + 1);
                check(go_c + 1 - rise_c == VLEAD[v], "R4 lead", go_c + 1 - rise_c, VLEAD[v]);
                check(gaps == 0, "R3 frame covered", gaps, 0);
                check(fall_c == done_c + 1, "R5 release", fall_c, done_c + 1);
                check(go_n == 1, "R4 single frame", go_n, 1);
            end else begin
                check(hi_n == 0, "R8 de held low", hi_n, 0);
                check(go_c + 1 - w == VLEAD[v], "R8 no lead", go_c + 1 - w, VLEAD[v]);
            end
        end
        de_enable = 1;

        // R7: second write inside the lead wait
        clear_mon();
        write_at_phase(6, w);
        @(posedge clk); #1;
        tx_write = 1;
        @(posedge clk); #1;
        tx_write = 0;
        wait_idle();
        repeat (40) @(posedge clk);
        #1;
        check(go_n == 1, "R7 no extra frame", go_n, 1);
        check(go_c + 1 - rise_c == 6 + P, "R7 lead not restarted", go_c + 1 - rise_c, 6 + P);

        // R6: write while a frame is in flight
        clear_mon();
        write_at_phase(2, w);
        for (int i = 0; i < 100 && go_n == 0; i++) begin
            @(posedge clk); #1;
        end
        repeat (20) @(posedge clk);
        #1;
        tx_write = 1;
        @(posedge clk); #1;
        tx_write = 0;
        wait_idle();
        check(go_n == 2, "R6 two frames", go_n, 2);
        check(go2_c == done1_c, "R6 chained go", go2_c, done1_c);
        check(fall_n == 1, "R6 one release", fall_n, 1);
        check(gaps == 0, "R3 chained coverage", gaps, 0);
        check(fall_c == done_c + 1, "R5 release after chain", fall_c, done_c + 1);
        check(badgo == 0, "R9 go while busy", badgo, 0);

        if (!finished) begin
            finished = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            total++; bad++;
            $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 0);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule